// File: doc/BRIEF.md
# Three-wire serial EEPROM target

This block behaves as the target side of a three-wire serial EEPROM with 1024 bits of storage. A host raises chip select, clocks a frame in on the serial data input with rising shift-clock edges, and gets read data or a ready/busy flag back on a serial output with its own drive-enable. The organization input picks the word shape: high gives 64 words of 16 bits, low gives 128 words of 8 bits. Both views share one array, so byte address 2k is the low half and 2k+1 the high half of 16-bit word k.

Chip select, shift clock and data input are brought into the system-clock domain through synchronizer chains, and shift-clock rising edges are found there. Seven instructions are decoded: read, write, erase, four whole-array or latch commands that reuse the top address bits, and an enable latch that guards all programming. Each program operation starts a self-timed cycle of `PROG_CYCLES` system clocks. The host polls it by dropping and then raising chip select.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, the enable latch is clear, and every location reads as all ones.
- R2: Zeros clocked in before the start bit are ignored. A frame is a 1 start bit, a 2-bit opcode and an address: 6 bits when organization is high, 7 bits when low. All bits go MSB first and are sampled on shift-clock rising edges.
- R3: Read (opcode 10) drives a 0 dummy bit after the last address bit. It then shifts out 16 data bits (x16) or 8 data bits (x8), MSB first, one per shift-clock rise. One further rise releases the output.
- R4: Read returns the stored data whether the enable latch is set or clear.
- R5: Opcode 00 takes its sub-command from the two highest address bits. 11 sets the enable latch and 00 clears it. The latch holds its value until the other command or a reset.
- R6: Write (opcode 01) stores the data word that follows the address into one location. Write-all (00 with sub-command 01) stores it into every location. In x8 mode an even byte address is the low half of a 16-bit word and an odd address is the high half.
- R7: Erase (opcode 11) sets one location to all ones. Erase-all (00 with sub-command 10) sets every location to all ones.
- R8: Write, write-all, erase and erase-all leave the memory unchanged while the enable latch is clear.
- R9: A program operation starts a busy period of PROG_CYCLES system clocks. If chip select is dropped and raised again during that period, the output is driven 0 while busy and 1 once the period has ended, until chip select falls.
- R10: If chip select is raised after the busy period has already ended, the output stays released.
- R11: A frame clocked in while a busy period is running is discarded.
- R12: The output enable is low while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_i | input | 1 | Organization: 1 = 16-bit words, 0 = 8-bit words |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Drive enable for do_o |

## Verification
The bench builds the block with PROG_CYCLES set to 300 and keeps 1024 bits and a two-stage synchronizer. The short program cycle lets one run do three things: poll the busy phase, watch the flag turn to ready while chip select is held high, and raise chip select only after the cycle has ended. It can also overlap a discarded frame with a running cycle. It switches the organization input mid-run, so byte-lane placement is checked against data written through the 16-bit view.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [3:0] {
      S_OFF, S_HUNT, S_OPC, S_ADR, S_DAT, S_RDL, S_RD, S_STAT, S_HOLD
   } mw_state_t;

   localparam logic [1:0] OP_RD  = 2'b10;
   localparam logic [1:0] OP_WR  = 2'b01;
   localparam logic [1:0] OP_ER  = 2'b11;
   localparam logic [1:0] OP_SYS = 2'b00;

   localparam logic [1:0] SUB_EN   = 2'b11;
   localparam logic [1:0] SUB_ERAL = 2'b10;
   localparam logic [1:0] SUB_WRAL = 2'b01;
   localparam logic [1:0] SUB_DIS  = 2'b00;

   typedef struct packed {
      logic go;
      logic all;
      logic fill;
   } mw_prog_t;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= d;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
   parameter int PROG_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(PROG_CYCLES + 1);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         cnt <= '0;
      else if (start)     cnt <= TW'(PROG_CYCLES);
      else if (cnt != '0) cnt <= cnt - 1'b1;

   assign busy = (cnt != '0);

   // R9
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/mw_array.sv
module mw_array
   import mw_pkg::*;
#(
   parameter int MEM_BITS = 1024,
   parameter int DW       = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               org,
   input  mw_prog_t                           prog,
   input  logic                               busy,
   input  logic [$clog2(MEM_BITS/DW*2)-1:0]   addr,
   input  logic [DW-1:0]                      wdata,
   output logic [DW-1:0]                      rdata
);
   localparam int WORDS = MEM_BITS / DW;
   localparam int WSW   = $clog2(WORDS);
   localparam int HB    = DW / 2;

   logic [DW-1:0]  mem [WORDS];
   logic [WSW-1:0] wsel;
   logic           hi;
   logic [DW-1:0]  wval, wmask, word;

   always_comb begin
      wsel  = org ? addr[WSW-1:0] : addr[WSW:1];
      hi    = !org && addr[0];
      wval  = prog.fill ? '1 : (org ? wdata : {wdata[HB-1:0], wdata[HB-1:0]});
      if (org || prog.all) wmask = '1;
      else if (hi)         wmask = {{HB{1'b1}}, {HB{1'b0}}};
      else                 wmask = {{HB{1'b0}}, {HB{1'b1}}};
   end

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)
               mem[g] <= '1;
            else if (prog.go && (prog.all || wsel == WSW'(g)))
               mem[g] <= (mem[g] & ~wmask) | (wval & wmask);
      end
   endgenerate

   always_comb begin
      word  = mem[wsel];
      rdata = org ? word : {{HB{1'b0}}, (hi ? word[DW-1:HB] : word[HB-1:0])};
   end

   // R11
   no_prog_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog.go |-> !busy);
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
   import mw_pkg::*;
#(
   parameter int MEM_BITS = 1024,
   parameter int DW       = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         org,
   input  logic                         cs,
   input  logic                         sk,
   input  logic                         di,
   input  logic                         busy,
   input  logic [DW-1:0]                rdata,
   output mw_prog_t                     prog,
   output logic [$clog2(MEM_BITS/8)-1:0] addr,
   output logic [DW-1:0]                wdata,
   output logic                         dout,
   output logic                         doe
);
   localparam int AW8 = $clog2(MEM_BITS / 8);
   localparam int HB  = DW / 2;
   localparam int CW  = $clog2(DW + 1);

   mw_state_t      st;
   logic           sk_q, sk_rise;
   logic [CW-1:0]  cnt, alast, dlast, dnum;
   logic [1:0]     op, sub;
   logic [AW8-1:0] adr, adr_n;
   logic [DW-1:0]  dat, sh;
   logic           wen, do_q, oe_q;
   mw_prog_t       prog_q;

   always_comb begin
      sk_rise = sk && !sk_q;
      alast   = org ? CW'(AW8 - 2) : CW'(AW8 - 1);
      dnum    = org ? CW'(DW) : CW'(HB);
      dlast   = dnum - 1'b1;
      adr_n   = {adr[AW8-2:0], di};
      sub     = org ? adr_n[AW8-2 -: 2] : adr_n[AW8-1 -: 2];
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sk_q <= 1'b0;
      else        sk_q <= sk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_OFF; cnt <= '0; op <= '0; adr <= '0; dat <= '0; sh <= '0;
         wen <= 1'b0; do_q <= 1'b0; oe_q <= 1'b0; prog_q <= '0;
      end else begin
         prog_q <= '0;
         if (!cs) begin
            st   <= S_OFF;
            oe_q <= 1'b0;
         end else begin
            case (st)
               S_OFF: begin
                  st   <= busy ? S_STAT : S_HUNT;
                  oe_q <= busy;
                  do_q <= 1'b0;
               end
               S_STAT: begin
                  oe_q <= 1'b1;
                  do_q <= !busy;
               end
               S_HUNT: if (sk_rise && di) begin
                  st  <= S_OPC;
                  cnt <= '0;
               end
               S_OPC: if (sk_rise) begin
                  op  <= {op[0], di};
                  cnt <= cnt + 1'b1;
                  if (cnt == CW'(1)) begin
                     st  <= S_ADR;
                     cnt <= '0;
                  end
               end
               S_ADR: if (sk_rise) begin
                  adr <= adr_n;
                  cnt <= cnt + 1'b1;
                  if (cnt == alast) begin
                     cnt <= '0;
                     st  <= S_HOLD;
                     case (op)
                        OP_RD: begin
                           st   <= S_RDL;
                           oe_q <= 1'b1;
                           do_q <= 1'b0;
                        end
                        OP_WR: st <= S_DAT;
                        OP_ER: prog_q <= {wen, 1'b0, 1'b1};
                        default: case (sub)
                           SUB_EN:   wen <= 1'b1;
                           SUB_DIS:  wen <= 1'b0;
                           SUB_ERAL: prog_q <= {wen, 1'b1, 1'b1};
                           default:  st <= S_DAT;
                        endcase
                     endcase
                  end
               end
               S_DAT: if (sk_rise) begin
                  dat <= {dat[DW-2:0], di};
                  cnt <= cnt + 1'b1;
                  if (cnt == dlast) begin
                     prog_q <= {wen, (op == OP_SYS), 1'b0};
                     st     <= S_HOLD;
                  end
               end
               S_RDL: begin
                  sh  <= org ? rdata : {rdata[HB-1:0], {HB{1'b0}}};
                  cnt <= '0;
                  st  <= S_RD;
               end
               S_RD: if (sk_rise) begin
                  if (cnt == dnum) begin
                     oe_q <= 1'b0;
                     st   <= S_HOLD;
                  end else begin
                     do_q <= sh[DW-1];
                     sh   <= {sh[DW-2:0], 1'b0};
                     cnt  <= cnt + 1'b1;
                  end
               end
               default: oe_q <= 1'b0;
            endcase
         end
      end
   end

   assign prog  = prog_q;
   assign addr  = adr;
   assign wdata = dat;
   assign dout  = do_q;
   assign doe   = oe_q;

   // R12
   hiz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> !doe);

   // R10
   no_late_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs) && !busy) |=> !doe);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
   import mw_pkg::*;
#(
   parameter int MEM_BITS    = 1024,
   parameter int DW          = 16,
   parameter int PROG_CYCLES = 5000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic org_i,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   output logic do_o,
   output logic do_oe_o
);
   localparam int AW8 = $clog2(MEM_BITS / 8);

   logic [2:0]     raw, syn;
   logic           busy;
   mw_prog_t       prog;
   logic [AW8-1:0] addr;
   logic [DW-1:0]  wdata, rdata;

   assign raw = {cs_i, sk_i, di_i};

   generate
      for (genvar i = 0; i < 3; i++) begin : g_sync
         mw_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(syn[i]));
      end
   endgenerate

   mw_ctrl #(.MEM_BITS(MEM_BITS), .DW(DW)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .org(org_i),
      .cs(syn[2]), .sk(syn[1]), .di(syn[0]),
      .busy(busy), .rdata(rdata), .prog(prog), .addr(addr),
      .wdata(wdata), .dout(do_o), .doe(do_oe_o));

   mw_array #(.MEM_BITS(MEM_BITS), .DW(DW)) i_array (
      .clk(clk), .rst_n(rst_n), .org(org_i), .prog(prog), .busy(busy),
      .addr(addr), .wdata(wdata), .rdata(rdata));

   mw_timer #(.PROG_CYCLES(PROG_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(prog.go), .busy(busy));
endmodule

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
   localparam int PROG = 300;

   logic clk = 1'b0, rst_n = 1'b0;
   logic org = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic dout, doe;
   logic got_do, got_oe, dum_do, dum_oe;
   logic [15:0] rv;
   int nchk = 0, nbad = 0;

   always #4 clk = ~clk;

   mw_eeprom #(.PROG_CYCLES(PROG)) i_mw_eeprom (
      .clk(clk), .rst_n(rst_n), .org_i(org), .cs_i(cs), .sk_i(sk),
      .di_i(di), .do_o(dout), .do_oe_o(doe));

   // kind: 0 write, 1 erase, 2 read and compare
   localparam logic [24:0] VEC [9] = '{
      {2'd0, 7'd5,  16'hA5C3}, {2'd0, 7'd0,  16'h1234}, {2'd0, 7'd63, 16'h8001},
      {2'd2, 7'd5,  16'hA5C3}, {2'd2, 7'd0,  16'h1234}, {2'd2, 7'd63, 16'h8001},
      {2'd1, 7'd5,  16'h0000}, {2'd2, 7'd5,  16'hFFFF}, {2'd2, 7'd1,  16'hFFFF}};

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bit1(input logic b);
      di = b; wt(6); sk = 1'b1; wt(6);
      got_do = dout; got_oe = doe; sk = 1'b0;
   endtask

   task automatic send(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) bit1(v[i]);
   endtask

   task automatic begin_cmd();
      cs = 1'b1; wt(6);
   endtask

   task automatic end_cmd();
      wt(4); cs = 1'b0; wt(6);
   endtask

   task automatic head(input logic [1:0] op, input logic [6:0] a);
      begin_cmd(); bit1(1'b1); send({14'd0, op}, 2); send({9'd0, a}, org ? 6 : 7);
   endtask

   task automatic rd_body(output logic [15:0] d);
      dum_do = got_do; dum_oe = got_oe; d = '0;
      for (int i = 0; i < (org ? 16 : 8); i++) begin
         bit1(1'b0); d = {d[14:0], got_do};
      end
   endtask

   task automatic rd(input logic [6:0] a, output logic [15:0] d);
      head(2'b10, a); rd_body(d); end_cmd();
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d);
      head(2'b01, a); send(d, org ? 16 : 8); end_cmd();
   endtask

   task automatic sys(input logic [1:0] s);
      head(2'b00, org ? {1'b0, s, 4'b0} : {s, 5'b0});
   endtask

   task automatic settle();
      wt(PROG + 60);
   endtask

   initial begin
      wt(150000);
      nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nchk + 1, nbad);
      $finish;
   end

   initial begin
      wt(5); rst_n = 1'b1; wt(5);
      chk("R1 oe after reset", {15'd0, doe}, 16'h0);
      rd(7'd3, rv);
      chk("R1 erased after reset", rv, 16'hFFFF);
      chk("R3 dummy bit value", {15'd0, dum_do}, 16'h0);
      chk("R3 dummy bit driven", {15'd0, dum_oe}, 16'h1);
      chk("R12 released with cs low", {15'd0, doe}, 16'h0);

      wr(7'd3, 16'h0000); settle();
      rd(7'd3, rv);
      chk("R8 write ignored with latch clear", rv, 16'hFFFF);
      chk("R4 read with latch clear", rv, 16'hFFFF);

      sys(2'b11); end_cmd();
      foreach (VEC[k]) begin
         case (VEC[k][24:23])
            2'd0: begin wr(VEC[k][22:16], VEC[k][15:0]); settle(); end
            2'd1: begin head(2'b11, VEC[k][22:16]); end_cmd(); settle(); end
            default: begin
               rd(VEC[k][22:16], rv);
               chk("R6 R7 R5 table read", rv, VEC[k][15:0]);
            end
         endcase
      end

      head(2'b10, 7'd0); rd_body(rv); bit1(1'b0);
      chk("R3 released after last bit", {15'd0, got_oe}, 16'h0);
      end_cmd();

      wr(7'd10, 16'h0BEE);
      begin_cmd();
      chk("R9 status driven", {15'd0, doe}, 16'h1);
      chk("R9 busy shows 0", {15'd0, dout}, 16'h0);
      wt(PROG + 40);
      chk("R9 ready shows 1", {15'd0, dout}, 16'h1);
      chk("R9 ready still driven", {15'd0, doe}, 16'h1);
      cs = 1'b0; wt(6);
      chk("R12 status released", {15'd0, doe}, 16'h0);

      wr(7'd11, 16'h0FED); settle();
      begin_cmd();
      chk("R10 no late status", {15'd0, doe}, 16'h0);
      end_cmd();

      wr(7'd7, 16'h1111);
      wr(7'd8, 16'h2222); settle();
      rd(7'd8, rv);
      chk("R11 frame during busy discarded", rv, 16'hFFFF);
      rd(7'd7, rv);
      chk("R11 first write kept", rv, 16'h1111);

      sys(2'b10); end_cmd(); settle();
      rd(7'd7, rv);  chk("R7 erase all word 7", rv, 16'hFFFF);
      rd(7'd0, rv);  chk("R7 erase all word 0", rv, 16'hFFFF);

      sys(2'b01); send(16'h3C96, 16); end_cmd(); settle();
      rd(7'd17, rv); chk("R6 write all word 17", rv, 16'h3C96);
      rd(7'd40, rv); chk("R6 write all word 40", rv, 16'h3C96);

      org = 1'b0; wt(4);
      wr(7'd9, 16'h005A); settle();
      rd(7'd9, rv); chk("R6 x8 byte 9", rv, 16'h005A);
      rd(7'd8, rv); chk("R6 x8 byte 8 low half", rv, 16'h0096);
      org = 1'b1; wt(4);
      rd(7'd4, rv); chk("R6 word 4 halves", rv, 16'h5A96);

      begin_cmd(); send(16'h0, 3); bit1(1'b1); send(16'h2, 2); send(16'h4, 6);
      rd_body(rv); end_cmd();
      chk("R2 leading zeros ignored", rv, 16'h5A96);

      sys(2'b00); end_cmd();
      wr(7'd4, 16'h0000); settle();
      rd(7'd4, rv);
      chk("R5 disable blocks write", rv, 16'h5A96);

      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule